// File: doc/BRIEF.md
# Fuse-programmable AND-OR logic array

This block is a small programmable logic core with sixteen dedicated inputs and one complementary output pair. Each input is split into a true literal and an inverted literal, which gives 32 array lines. A programmable AND plane forms sixteen product terms from those lines. Two fixed 8-input OR gates gather the terms, one gate for the lower eight and one for the upper eight. A last stage combines the two OR results into an OR output and a NOR output. Nothing is fed back from the outputs into the array, so the whole path from inputs to outputs is combinational.

The connection map has 512 bits and is held in an internal fuse register. It is written once after reset through a three-wire serial port: a clock, a shift enable and a data bit. While the map is incomplete both outputs are held low. Once the last bit has been accepted, the outputs follow the inputs with no clock involved. To load a different map, reset the block and shift the new map in.

Top module: `pla_core`

## Requirements
- R1: At the first rising clock edge with `rst_n` low, the block clears the fuse map and the bit count. After that edge `cfg_done`, `q_or` and `q_nor` are all 0.
- R2: Map bit k has index term*32 + line. It is the k-th bit taken from `cfg_data` on a rising `clk` edge while `cfg_en` is 1, with the first bit taken being bit 0. `cfg_done` becomes 1 on the edge that takes the 512th bit, and it stays 0 through 511 bits.
- R3: Once `cfg_done` is 1, any further `cfg_en` and `cfg_data` activity changes neither the map nor `cfg_done`. Only a reset clears them.
- R4: While `cfg_done` is 0, both `q_or` and `q_nor` are 0 whatever the inputs are.
- R5: Array line 2p is the true value of the input assigned to pair p, and line 2p+1 is its inverse. `in_pins` bits 0 to 15 stand for package inputs 1 to 9, 11 to 14 and 17 to 19 in that order. Pairs 0 to 15 take, in order, the inputs 2, 1, 3, 19, 4, 18, 5, 17, 6, 14, 7, 13, 8, 12, 9, 11.
- R6: Each product term is the AND of the lines whose map bit (value 1) is set for that term. A term with no bit set is 0. A term that connects both lines of one pair is 0.
- R7: Terms 0 to 7 feed OR group A and terms 8 to 15 feed OR group B. When `cfg_done` is 1, `q_or` = A|B.
- R8: When `cfg_done` is 1, `q_nor` is always the inverse of `q_or`.
- R9: The block can be set up as an equality comparator. Operand A bit i is the input on pair i, and operand B bit i is the input on pair i+8. Terms 2i and 2i+1 hold the two mismatch products for bit i. With that map, `q_nor` is 1 exactly when the two operands are equal, and `q_or` is 1 exactly when they differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the map bit |
| cfg_data | input | 1 | Serial map bit, bit 0 first |
| in_pins | input | 16 | Dedicated logic inputs, in package order |
| cfg_done | output | 1 | Map fully loaded |
| q_or | output | 1 | OR of both OR groups |
| q_nor | output | 1 | NOR of both OR groups |

## Verification
The hardest conditions to reach from the ports are the boundary of the load count, and a locked map being hit by further shift traffic. Each needs an exact number of serial bits before it can be seen. The bench shifts exactly 511 bits and checks that the outputs are still held low, then sends the final bit. After the load it shifts an inverted map with the enable active and checks that the outputs still follow the first map. Conflicting-literal and empty-term maps are loaded after a reset. Random inputs then show that those terms never assert.

// File: rtl/pla_pkg.sv
// Package: shared sizes and the fixed input-to-pair routing of the array.
// Assumes two OR groups of equal size.
package pla_pkg;
    localparam int N_IN      = 16;
    localparam int N_LINES   = 2 * N_IN;
    localparam int N_TERMS   = 16;
    localparam int N_GROUPS  = 2;
    localparam int FUSE_BITS = N_TERMS * N_LINES;

    // Returns the in_pins bit that feeds array pair p.
    function automatic int pair_source(input int p);
        case (p)
            0:  return 1;   1:  return 0;   2:  return 2;   3:  return 15;
            4:  return 3;   5:  return 14;  6:  return 4;   7:  return 13;
            8:  return 5;   9:  return 12;  10: return 6;   11: return 11;
            12: return 7;   13: return 10;  14: return 8;   default: return 9;
        endcase
    endfunction
endpackage

// File: rtl/pla_fuse_loader.sv
// Fuse loader: takes the map in serially, LSB first, and counts the bits.
// The map locks once BITS bits have arrived; only a reset reopens it.
module pla_fuse_loader #(
    parameter int BITS = 512
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_en,
    input  logic            cfg_data,
    output logic [BITS-1:0] fuse_q,
    output logic            done_q
);
    localparam int CW = $clog2(BITS + 1);
    logic [CW-1:0] count_q;

    // Shift in one map bit on each enabled edge until the map is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fuse_q  <= '0;
            count_q <= '0;
            done_q  <= 1'b0;
        end else if (cfg_en && !done_q) begin
            fuse_q  <= {cfg_data, fuse_q[BITS-1:1]};
            count_q <= count_q + 1'b1;
            done_q  <= (count_q == CW'(BITS - 1));
        end
    end

    AST_DONE_ON_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(count_q) == CW'(BITS - 1) && $past(cfg_en))); // R2
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> done_q); // R3
    AST_MAP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> $stable(fuse_q)); // R3
endmodule

// File: rtl/pla_and_plane.sv
// AND plane: every term is the AND of the lines its fuse row connects.
// A row with no connection gives 0. Purely combinational.
module pla_and_plane #(
    parameter int LINES = 32,
    parameter int TERMS = 16
) (
    input  logic [LINES-1:0]       lines,
    input  logic [TERMS*LINES-1:0] fuse,
    output logic [TERMS-1:0]       terms
);
    for (genvar t = 0; t < TERMS; t++) begin : g_term
        logic [LINES-1:0] row;
        assign row = fuse[t*LINES +: LINES];
        // A term asserts when its row is not empty and every connected line is high.
        always_comb terms[t] = (|row) & (&(lines | ~row));
    end
endmodule

// File: rtl/pla_or_stage.sv
// OR stage: fixed groups of consecutive terms, merged into an OR/NOR pair.
// Both outputs are held low until enable is set.
module pla_or_stage #(
    parameter int TERMS  = 16,
    parameter int GROUPS = 2
) (
    input  logic [TERMS-1:0] terms,
    input  logic             enable,
    output logic             q_or,
    output logic             q_nor
);
    localparam int GSIZE = TERMS / GROUPS;
    logic [GROUPS-1:0] grp;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        // Reduce one block of consecutive terms.
        always_comb grp[g] = |terms[g*GSIZE +: GSIZE];
    end

    // Merge the group results into the gated complementary pair.
    always_comb begin
        q_or  = enable & (|grp);
        q_nor = enable & ~(|grp);
    end
endmodule

// File: rtl/pla_core.sv
// Top: routes the inputs into true and inverted lines, then runs loader,
// AND plane and OR stage. Assumes the map is loaded once after each reset.
module pla_core
    import pla_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_en,
    input  logic            cfg_data,
    input  logic [N_IN-1:0] in_pins,
    output logic            cfg_done,
    output logic            q_or,
    output logic            q_nor
);
    logic [FUSE_BITS-1:0] fuse;
    logic [N_LINES-1:0]   lines;
    logic [N_TERMS-1:0]   terms;

    for (genvar p = 0; p < N_IN; p++) begin : g_pair
        // Even line carries the input as it is, odd line its inverse.
        always_comb begin
            lines[2*p]   = in_pins[pair_source(p)];
            lines[2*p+1] = ~in_pins[pair_source(p)];
        end
    end

    pla_fuse_loader #(.BITS(FUSE_BITS)) u_loader (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_data(cfg_data),
        .fuse_q(fuse), .done_q(cfg_done));

    pla_and_plane #(.LINES(N_LINES), .TERMS(N_TERMS)) u_and (
        .lines(lines), .fuse(fuse), .terms(terms));

    pla_or_stage #(.TERMS(N_TERMS), .GROUPS(N_GROUPS)) u_or (
        .terms(terms), .enable(cfg_done), .q_or(q_or), .q_nor(q_nor));

    AST_HOLD_LOW_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> (!q_or && !q_nor)); // R4
    AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> (q_or != q_nor)); // R8
    AST_PAIR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q_or, q_nor})); // R8
endmodule

// File: tb/pla_core_test.sv
module pla_core_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, cfg_en = 1'b0, cfg_data = 1'b0;
    logic [15:0] in_pins = '0;
    logic cfg_done, q_or, q_nor;
    int n_checks = 0, n_fail = 0;

    pla_core uut (.clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_data(cfg_data),
                  .in_pins(in_pins), .cfg_done(cfg_done), .q_or(q_or), .q_nor(q_nor));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pair p reads in_pins bit SRC[p] (R5 routing table).
    localparam int SRC [16] = '{1, 0, 2, 15, 3, 14, 4, 13, 5, 12, 6, 11, 7, 10, 8, 9};

    function automatic logic [1:0] model(input logic [511:0] m, input logic [15:0] pins,
                                         input logic done);
        logic [31:0] ln;
        logic [15:0] t;
        logic a, b;
        for (int p = 0; p < 16; p++) begin
            ln[2*p] = pins[SRC[p]];
            ln[2*p+1] = ~pins[SRC[p]];
        end
        for (int k = 0; k < 16; k++) begin
            t[k] = (m[k*32 +: 32] != 0);
            for (int l = 0; l < 32; l++)
                if (m[k*32+l] && !ln[l]) t[k] = 1'b0;
        end
        a = |t[7:0];
        b = |t[15:8];
        if (!done) return 2'b00;
        return {a | b, ~(a | b)};
    endfunction

    function automatic logic [15:0] pins_from_ops(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] r = '0;
        for (int i = 0; i < 8; i++) begin
            r[SRC[i]] = a[i];
            r[SRC[i+8]] = b[i];
        end
        return r;
    endfunction

    function automatic logic [511:0] eq_map();
        logic [511:0] m = '0;
        for (int i = 0; i < 8; i++) begin
            m[(2*i)*32 + 2*i] = 1'b1;          // a_i
            m[(2*i)*32 + 2*(i+8) + 1] = 1'b1;  // ~b_i
            m[(2*i+1)*32 + 2*i + 1] = 1'b1;    // ~a_i
            m[(2*i+1)*32 + 2*(i+8)] = 1'b1;    // b_i
        end
        return m;
    endfunction

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got done/or/nor=%b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic shift_bits(input logic [511:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cfg_en = 1'b1;
            cfg_data = m[k];
        end
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    task automatic sweep(input string req, input logic [511:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            in_pins = 16'($urandom);
            #1;
            chk(req, {cfg_done, q_or, q_nor}, {1'b1, model(m, in_pins, 1'b1)});
        end
    endtask

    logic [511:0] m;

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        #1;
        chk("R1", {cfg_done, q_or, q_nor}, 3'b000);

        // Partial load: 511 bits, outputs held low (R2, R4).
        m = '0;
        m[0*32 + 0] = 1'b1;                  // term 0: pair 0 true
        m[15*32 + 7] = 1'b1;                 // term 15: pair 3 inverse
        shift_bits(m, 511);
        in_pins = 16'hFFFF;
        #1;
        chk("R2", {cfg_done, q_or, q_nor}, 3'b000);
        chk("R4", {cfg_done, q_or, q_nor}, 3'b000);
        @(negedge clk);
        cfg_en = 1'b1;
        cfg_data = m[511];
        @(negedge clk);
        cfg_en = 1'b0;
        #1;
        chk("R2", {cfg_done, 2'b00}, 3'b100);
        // Routing: in_pins[1] alone asserts term 0 (R5, R7).
        in_pins = 16'h0002 | 16'h8000;
        #1;
        chk("R5", {cfg_done, q_or, q_nor}, 3'b110);
        in_pins = 16'h8000;
        #1;
        chk("R5", {cfg_done, q_or, q_nor}, 3'b101);
        in_pins = 16'h0000;                  // pin 19 low -> term 15 in group B
        #1;
        chk("R7", {cfg_done, q_or, q_nor}, 3'b110);
        sweep("R7", m, 40);

        // Locked map: shift inverted map with enable, behaviour unchanged (R3).
        shift_bits(~m, 300);
        chk("R3", {cfg_done, 2'b00}, 3'b100);
        sweep("R3", m, 30);

        // Conflicting literals and empty rows never assert (R6).
        do_reset();
        m = '0;
        for (int k = 0; k < 16; k++) begin
            m[k*32 + 2*k] = 1'b1;
            m[k*32 + 2*k + 1] = 1'b1;
        end
        shift_bits(m, 512);
        sweep("R6", m, 30);
        do_reset();
        m = '0;
        shift_bits(m, 512);
        in_pins = 16'hFFFF;
        #1;
        chk("R6", {cfg_done, q_or, q_nor}, 3'b101);
        in_pins = 16'h0000;
        #1;
        chk("R6", {cfg_done, q_or, q_nor}, 3'b101);

        // Multi-literal terms across random maps (R6, R7, R8).
        for (int r = 0; r < 4; r++) begin
            do_reset();
            m = '0;
            for (int k = 0; k < 16; k++)
                for (int j = 0; j < 2; j++) m[k*32 + 2*($urandom % 16) + ($urandom % 2)] = 1'b1;
            shift_bits(m, 512);
            sweep("R8", m, 40);
        end

        // Equality comparator (R9).
        do_reset();
        m = eq_map();
        shift_bits(m, 512);
        for (int i = 0; i < 60; i++) begin
            logic [7:0] a, b;
            a = 8'($urandom);
            b = (i % 2 == 0) ? a : 8'($urandom);
            if (i == 1) b = a ^ 8'h80;
            if (i == 3) b = a ^ 8'h01;
            in_pins = pins_from_ops(a, b);
            #1;
            chk("R9", {cfg_done, q_or, q_nor}, {1'b1, a != b, a == b});
        end
        in_pins = pins_from_ops(8'h00, 8'h00);
        #1;
        chk("R9", {cfg_done, q_or, q_nor}, 3'b101);
        in_pins = pins_from_ops(8'hFF, 8'hFF);
        #1;
        chk("R9", {cfg_done, q_or, q_nor}, 3'b101);

        // Reset after a load clears done and outputs (R1).
        do_reset();
        #1;
        chk("R1", {cfg_done, q_or, q_nor}, 3'b000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule